// File: doc/BRIEF.md
# Symmetric Dual-Slope PWM Timer

This block is a 16-bit timer. It counts up from zero to a programmable TOP value and then back down to zero. Two compare channels drive PWM pins from the count. Software writes each channel's compare value into a holding register. That value moves into the active compare register only on the timer tick at which the count sits at zero (BOTTOM). Because of this, the rising and falling slopes of every period have the same length and each pulse is centred in its period.

TOP comes from one of two places. The first is a capture register that is written directly. The second is channel A's buffered compare register, in which case channel A gives up its pin. A prescaler divides the clock to form the timer tick. Four sticky flags report reaching TOP, reaching BOTTOM and a match on either channel.

The count direction is a two-state machine:
- DIR_UP moves to DIR_DOWN on the reversal transition, taken when the count has reached TOP.
- DIR_DOWN moves to DIR_UP on the bottom transition, taken when the count steps from 1 to 0.
- With TOP at zero, DIR_UP stays in place and the count holds at 0.

Top module: `sym_pwm_timer`

## Requirements
- R1: On each tick the count rises by one from 0 to TOP, then falls by one back to 0. Each end value is held for exactly one tick, so one period is 2×TOP ticks. With TOP at 0 the count holds at 0. If the count is at or above TOP while rising, it reverses on that tick.
- R2: With `top_is_cha`=0, TOP is the capture register, and a write to it takes effect on the next clock. With `top_is_cha`=1, TOP is channel A's active compare value, and `pwm_a` is held low.
- R3: Writes to a channel's compare value land in a holding register. That value becomes active only on a tick where the count is 0.
- R4: Flag bit 1 (BOTTOM) sets on the clock after a tick where the count is 0. The compare load happens on that same tick.
- R5: Flag bit 0 (TOP) sets on the clock after a tick where the count equals TOP.
- R6: Flag bit 2 (channel A) and flag bit 3 (channel B) set on the clock after a tick where the count equals that channel's active compare value.
- R7: In mode 2 (non-inverted), a channel's pin goes low after a match while rising and goes high after a match while falling. The count 0 and TOP ticks count as rising.
- R8: In mode 3 (inverted), a channel's pin goes high after a match while rising and goes low after a match while falling.
- R9: A compare value above TOP never matches, and that channel's pin keeps its level.
- R10: In modes 0 and 1, a channel's pin is driven low.
- R11: `pre_sel` selects the tick rate. The codes are:
  - 1: every clock
  - 2: every 8 clocks
  - 3: every 64 clocks
  - 4: every 256 clocks
  - 5: every 1024 clocks
  - 0, 6 and 7: no tick, and the count holds.
- R12: Flags are sticky. Writing 1 to a bit of `flag_clr` clears that flag. A set in the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pre_sel | input | 3 | Prescaler code |
| top_is_cha | input | 1 | 1: channel A compare is TOP; 0: capture register is TOP |
| wr_cha | input | 1 | Write `wr_data` into channel A holding register |
| wr_chb | input | 1 | Write `wr_data` into channel B holding register |
| wr_cap | input | 1 | Write `wr_data` into capture register |
| wr_data | input | 16 | Write data |
| mode_a | input | 2 | Channel A output mode |
| mode_b | input | 2 | Channel B output mode |
| flag_clr | input | 4 | Write-one-to-clear strobes for the flags |
| count | output | 16 | Current count |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| flags | output | 4 | {match B, match A, BOTTOM, TOP} |

## Verification
The assertions check on every cycle that:
- a falling count steps down by exactly one;
- the count is frozen when no tick occurs;
- active compare values change only at BOTTOM;
- pin edges follow the mode's direction rule;
- a flag never drops without a clear strobe.

The bench's scenarios show the rest:
- the full period shape and where TOP lands;
- a change of TOP source mid-count;
- the deferral of compare writes to the next BOTTOM;
- compare values above TOP;
- set-over-clear collisions;
- the actual tick spacing at each prescaler code.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        OM_OFF0   = 2'd0,
        OM_OFF1   = 2'd1,
        OM_NONINV = 2'd2,
        OM_INV    = 2'd3
    } omode_e;

    localparam int FLAG_TOP = 0;
    localparam int FLAG_BOT = 1;
    localparam int FLAG_MA  = 2;
    localparam int FLAG_MB  = 3;
    localparam int N_FLAGS  = 4;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PRE_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    always_comb begin
        unique case (sel)
            3'd1:    tick = 1'b1;
            3'd2:    tick = &div_q[2:0];
            3'd3:    tick = &div_q[5:0];
            3'd4:    tick = &div_q[7:0];
            3'd5:    tick = &div_q[9:0];
            default: tick = 1'b0;
        endcase
    end

    p_div8_gap_r11: assert property (@(posedge clk) disable iff (rst)
        (sel == 3'd2 && $past(sel) == 3'd2 && tick) |=> !tick);
endmodule

// File: rtl/tmr_updown.sv
module tmr_updown
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] top_val,
    output logic [W-1:0] cnt,
    output dir_e         dir,
    output logic         at_top,
    output logic         at_bot
);
    dir_e         st_q, st_d;
    logic [W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= DIR_UP;
            cnt_q <= '0;
        end else if (tick) begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state: reversal and bottom transitions
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            DIR_UP: begin
                if (cnt_q >= top_val) begin
                    if (top_val != '0) begin
                        cnt_d = cnt_q - 1'b1;
                        st_d  = (cnt_q == W'(1)) ? DIR_UP : DIR_DOWN;
                    end else begin
                        cnt_d = '0;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            DIR_DOWN: begin
                cnt_d = cnt_q - 1'b1;
                st_d  = (cnt_q == W'(1)) ? DIR_UP : DIR_DOWN;
            end
        endcase
    end

    // outputs
    always_comb begin
        cnt    = cnt_q;
        dir    = st_q;
        at_top = tick && (cnt_q == top_val);
        at_bot = tick && (cnt_q == '0);
    end

    p_down_step_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && st_q == DIR_DOWN) |=> cnt_q == $past(cnt_q) - 1'b1);
    p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  dir_e         dir,
    input  logic         at_bot,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [1:0]   mode,
    input  logic         masked,
    output logic         match,
    output logic         pin,
    output logic [W-1:0] act
);
    logic [W-1:0] hold_q, act_q;
    logic         pin_q;
    omode_e       om;

    assign om    = omode_e'(mode);
    assign match = tick && (cnt == act_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            act_q  <= '0;
            pin_q  <= 1'b0;
        end else begin
            if (we)     hold_q <= wdata;
            if (at_bot) act_q  <= hold_q;
            if (match && mode[1])
                pin_q <= (dir == DIR_DOWN) ^ (om == OM_INV);
        end
    end

    assign pin = (mode[1] && !masked) ? pin_q : 1'b0;
    assign act = act_q;

    p_load_at_bottom_r3: assert property (@(posedge clk) disable iff (rst)
        !at_bot |=> act_q == $past(act_q));
    p_noninv_up_r7: assert property (@(posedge clk) disable iff (rst)
        (match && om == OM_NONINV && dir == DIR_UP) |=> !pin_q);
    p_inv_up_r8: assert property (@(posedge clk) disable iff (rst)
        (match && om == OM_INV && dir == DIR_UP) |=> pin_q);
    p_hold_no_match_r9: assert property (@(posedge clk) disable iff (rst)
        !match |=> $stable(pin_q));
endmodule

// File: rtl/sym_pwm_timer.sv
module sym_pwm_timer
    import tmr_pkg::*;
#(
    parameter int W     = 16,
    parameter int PRE_W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   pre_sel,
    input  logic         top_is_cha,
    input  logic         wr_cha,
    input  logic         wr_chb,
    input  logic         wr_cap,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   mode_a,
    input  logic [1:0]   mode_b,
    input  logic [3:0]   flag_clr,
    output logic [W-1:0] count,
    output logic         pwm_a,
    output logic         pwm_b,
    output logic [3:0]   flags
);
    localparam int NCH = 2;

    logic         tick, at_top, at_bot;
    dir_e         dir;
    logic [W-1:0] cnt, cap_q, top_val;
    logic [NCH-1:0]         ch_we, ch_mask, ch_match, ch_pin;
    logic [NCH-1:0][1:0]    ch_mode;
    logic [NCH-1:0][W-1:0]  ch_act;
    logic [N_FLAGS-1:0]     ev, flags_q;

    tmr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst(rst), .sel(pre_sel), .tick(tick)
    );

    always_ff @(posedge clk) begin
        if (rst)         cap_q <= '0;
        else if (wr_cap) cap_q <= wr_data;
    end

    assign top_val = top_is_cha ? ch_act[0] : cap_q;

    tmr_updown #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .top_val(top_val),
        .cnt(cnt), .dir(dir), .at_top(at_top), .at_bot(at_bot)
    );

    assign ch_we   = {wr_chb, wr_cha};
    assign ch_mode = {mode_b, mode_a};
    assign ch_mask = {1'b0, top_is_cha};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tmr_cmp_chan #(.W(W)) u_ch (
            .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .dir(dir),
            .at_bot(at_bot), .we(ch_we[c]), .wdata(wr_data),
            .mode(ch_mode[c]), .masked(ch_mask[c]),
            .match(ch_match[c]), .pin(ch_pin[c]), .act(ch_act[c])
        );
    end

    always_comb begin
        ev           = '0;
        ev[FLAG_TOP] = at_top;
        ev[FLAG_BOT] = at_bot;
        ev[FLAG_MA]  = ch_match[0];
        ev[FLAG_MB]  = ch_match[1];
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~flag_clr) | ev;
    end

    for (genvar f = 0; f < N_FLAGS; f++) begin : g_fchk
        p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
            (flags_q[f] && !flag_clr[f]) |=> flags_q[f]);
        p_set_wins_r12: assert property (@(posedge clk) disable iff (rst)
            ev[f] |=> flags_q[f]);
    end

    p_cha_masked_r2: assert property (@(posedge clk) disable iff (rst)
        top_is_cha |-> !pwm_a);

    assign count = cnt;
    assign pwm_a = ch_pin[0];
    assign pwm_b = ch_pin[1];
    assign flags = flags_q;
endmodule

// File: tb/sim_sym_pwm_timer.sv
`timescale 1ns/1ps
module sim_sym_pwm_timer;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  pre_sel;
    logic        top_is_cha, wr_cha, wr_chb, wr_cap;
    logic [15:0] wr_data;
    logic [1:0]  mode_a, mode_b;
    logic [3:0]  flag_clr;
    logic [15:0] count;
    logic        pwm_a, pwm_b;
    logic [3:0]  flags;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // model state
    logic [15:0] m_cnt, m_actA, m_actB, m_bufA, m_bufB, m_cap;
    logic        m_up, m_pa, m_pb;
    logic [3:0]  m_flags;

    always #4 clk = ~clk;

    sym_pwm_timer u0 (
        .clk(clk), .rst(rst), .pre_sel(pre_sel), .top_is_cha(top_is_cha),
        .wr_cha(wr_cha), .wr_chb(wr_chb), .wr_cap(wr_cap), .wr_data(wr_data),
        .mode_a(mode_a), .mode_b(mode_b), .flag_clr(flag_clr),
        .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b), .flags(flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_actA = 0; m_actB = 0; m_bufA = 0; m_bufB = 0; m_cap = 0;
        m_up = 1; m_pa = 0; m_pb = 0; m_flags = 0;
    endtask

    // one clock: advance model from current inputs, then compare at negedge
    task automatic step(input string tag);
        logic [15:0] topv;
        logic [3:0]  ev;
        ev = 0;
        if (pre_sel == 3'd1) begin
            topv = top_is_cha ? m_actA : m_cap;
            ev = {m_cnt == m_actB, m_cnt == m_actA, m_cnt == 0, m_cnt == topv};
            if (mode_a[1] && m_cnt == m_actA) m_pa = m_up ? (mode_a == 2'd3) : (mode_a == 2'd2);
            if (mode_b[1] && m_cnt == m_actB) m_pb = m_up ? (mode_b == 2'd3) : (mode_b == 2'd2);
            if (m_cnt == 0) begin m_actA = m_bufA; m_actB = m_bufB; end
            if (m_up) begin
                if (m_cnt >= topv) begin
                    if (topv != 0) begin m_cnt = m_cnt - 1; m_up = (m_cnt == 0); end
                    else m_cnt = 0;
                end else m_cnt = m_cnt + 1;
            end else begin
                m_cnt = m_cnt - 1; m_up = (m_cnt == 0);
            end
        end
        m_flags = (m_flags & ~flag_clr) | ev;
        if (wr_cha) m_bufA = wr_data;
        if (wr_chb) m_bufB = wr_data;
        if (wr_cap) m_cap  = wr_data;
        @(posedge clk);
        @(negedge clk);
        chk({"R1 count ", tag}, count, m_cnt);
        chk({"R7/R8 pwm_a ", tag}, pwm_a, (mode_a[1] && !top_is_cha) ? m_pa : 1'b0);
        chk({"R7/R8 pwm_b ", tag}, pwm_b, mode_b[1] ? m_pb : 1'b0);
        chk({"R12 flags ", tag}, flags, m_flags);
        wr_cha = 0; wr_chb = 0; wr_cap = 0; flag_clr = 0;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic do_reset();
        rst = 1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    task automatic measure(input logic [2:0] code, input int n);
        logic [15:0] last;
        int gap;
        do_reset();
        pre_sel = code; wr_cap = 1; wr_data = 16'd3;
        @(negedge clk); wr_cap = 0;
        last = count;
        for (int i = 0; i < 3000 && count == last; i++) @(negedge clk);
        last = count; gap = 0;
        for (int i = 0; i < 3000 && count == last; i++) begin @(negedge clk); gap++; end
        chk($sformatf("R11 tick gap code %0d", code), gap, n);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        pre_sel = 0; top_is_cha = 0; wr_cha = 0; wr_chb = 0; wr_cap = 0;
        wr_data = 0; mode_a = 0; mode_b = 0; flag_clr = 0;
        do_reset();
        chk("R1 reset count", count, 0);
        chk("R10 reset pins", {pwm_a, pwm_b}, 0);
        chk("R12 reset flags", flags, 0);

        // R1 R3 R5 R6 R7 R8 R9: sweep small TOP, compare values, both modes
        pre_sel = 1;
        for (int top = 1; top <= 5; top++)
            for (int cb = 0; cb <= top + 1; cb++)
                for (int ma = 2; ma <= 3; ma++) begin
                    mode_a = ma[1:0]; mode_b = 2'(5 - ma);
                    wr_cap = 1; wr_data = 16'(top); step("R2 cap write");
                    wr_cha = 1; wr_data = 16'((cb + 1) % (top + 2)); step("R3 cha write");
                    wr_chb = 1; wr_data = 16'(cb); step("R3 chb write");
                    run(4 * top + 3, (cb > top) ? "R9 above top" : "R4 R5 R6 sweep");
                end

        // R2: channel A as TOP, buffered; pin A masked
        top_is_cha = 1; mode_a = 2; mode_b = 2;
        wr_cha = 1; wr_data = 16'd4; step("R2 set A top");
        wr_chb = 1; wr_data = 16'd2; step("R2 set B");
        run(20, "R2 A is top");
        wr_cha = 1; wr_data = 16'd2; step("R3 A top change");
        run(20, "R3 A top deferred");

        // R2: capture TOP unbuffered, lowered while rising
        top_is_cha = 0;
        wr_cap = 1; wr_data = 16'd7; step("R2 cap 7");
        run(16, "R2 cap run");
        while (!(m_up && m_cnt == 4)) step("R2 seek");
        wr_cap = 1; wr_data = 16'd2; step("R2 cap lowered");
        run(12, "R2 cap lowered run");

        // R10: disconnected modes
        mode_a = 0; mode_b = 1;
        run(10, "R10 modes off");
        chk("R10 pins low", {pwm_a, pwm_b}, 0);

        // R12: set wins over clear with TOP=0
        wr_cap = 1; wr_data = 0; step("R12 top zero");
        run(16, "R12 top zero run");
        flag_clr = 4'hF; step("R12 clear vs set");
        chk("R12 set wins top/bot", flags[1:0], 2'b11);
        pre_sel = 0;
        flag_clr = 4'hF; step("R12 clear stopped");
        chk("R12 cleared", flags, 0);
        run(20, "R11 stopped");

        // R11: prescaler spacing
        measure(3'd1, 1);
        measure(3'd2, 8);
        measure(3'd3, 64);
        measure(3'd4, 256);
        measure(3'd5, 1024);
        measure(3'd6, 3000);
        measure(3'd0, 3000);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule